// File: doc/BRIEF.md
# Triggered Event Record Builder

The block keeps a short rolling history of per-crossing trigger data and, whenever a crossing is accepted, turns that crossing and its neighbours into a fixed record of 32 words, each 32 bits wide. Every clock carries one bunch crossing. The inputs are the aligned candidate values, a 16-bit report word, a downscale mode, the accept strobe and its qualifiers, and two error strobes. An accept is held back by two crossings so that the reports and calorimeter sums of the two following crossings can enter the record. The record is then stored as one compact entry in a 16-entry queue.

A reader takes the oldest entry and sends its 32 words, one per clock, with no gaps. The words are built by a word selector as they go out, so the stored entry never needs to be expanded. A start marker flags word 0. Six 32-bit running counters are copied into every record. An occupancy flag warns when the queue is nearly full. When the queue is full, the accept is dropped and only the counters record it.

Top module: `erb_record_builder`

## Requirements
- R1: After reset, rec_valid, rec_sop, rec_word and fifo_warn are all zero, and all six counters start from zero (the first record carries only its own contributions).
- R2: A record is 32 consecutive valid words. rec_sop is high on word 0 only. Two records never interleave. While rec_valid is low, rec_word and rec_sop are zero.
- R3: Word 0 holds the 3-bit downscale mode in bits 2:0. Word 1 holds the 12-bit crossing ID in bits 11:0. Words 2 to 7 hold, in bits 9:0, hadron 1, hadron 2, calorimeter sum, vertex veto, muon and electron. Word 8 holds the largest of hadron 1, hadron 2, muon and electron.
- R4: Words 14 to 18 hold the 16-bit report words of crossings N-2, N-1, N, N+1 and N+2 in bits 15:0, where N is the accepted crossing.
- R5: Word 19 holds the calorimeter sum of N-2 in bits 31:16 and that of N-1 in bits 15:0. Word 20 holds N+1 in bits 31:16 and N+2 in bits 15:0.
- R6: Words 9 to 13 and 27 to 31 are zero.
- R7: Word 21 counts accepts without the downscale flag, word 22 accepts with it, and word 23 accepts with the forced flag. The downscale and forced flags have no effect without an accept. Each record's counters include that record's own crossing.
- R8: Word 24 counts crossings with the sync-error strobe and word 25 counts crossings with the data-error strobe, whether accepted or not, up to and including the record's crossing.
- R9: Records leave in accept order. The queue holds 16 records. An accept that finds 16 records queued is not stored.
- R10: fifo_warn is high while 12 or more records are queued. Word 26 counts accepts, stored or dropped, that found 12 or more records queued.
- R11: With the queue empty, word 0 of the record appears on the fourth rising edge after the edge that samples the accepted crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_bcid | input | 12 | Crossing ID |
| x_had1 | input | 10 | Highest hadron energy |
| x_had2 | input | 10 | Second hadron energy |
| x_esum | input | 10 | Calorimeter sum |
| x_vveto | input | 10 | Vertex veto multiplicity |
| x_muon | input | 10 | Highest muon momentum |
| x_elec | input | 10 | Highest electron energy |
| x_report | input | 16 | Per-crossing report word |
| x_mode | input | 3 | Downscale mode |
| x_accept | input | 1 | Crossing accepted |
| x_dscl | input | 1 | Accept was downscaled |
| x_forced | input | 1 | Accept was forced |
| x_err_sync | input | 1 | Synchronisation error on this crossing |
| x_err_data | input | 1 | Data error on this crossing |
| rec_valid | output | 1 | Record word valid |
| rec_sop | output | 1 | First word of a record |
| rec_word | output | 32 | Record word |
| fifo_warn | output | 1 | Queue occupancy at or above warning level |

## Verification
If the history pipeline slips by one stage, words 14 to 20 of the very next record show the wrong neighbours. If a queue pointer goes stale, a record is repeated or lost, which the record count and the order of crossing IDs reveal when the following record comes out. A counter that misses or doubles an event shows up in words 21 to 26 of the next stored record. An occupancy error shows on fifo_warn within one clock of the push or pop that caused it.

// File: rtl/erb_pkg.sv
package erb_pkg;
  localparam int BCID_W    = 12;
  localparam int VAL_W     = 10;
  localparam int RPT_W     = 16;
  localparam int MODE_W    = 3;
  localparam int WORD_W    = 32;
  localparam int SUM_HALF  = WORD_W / 2;
  localparam int REC_WORDS = 32;
  localparam int IDX_W     = $clog2(REC_WORDS);
  localparam int HIST_DEPTH = 5;
  localparam int CENTER    = 2;
  localparam int NUM_CNT   = 6;
  localparam int CNT_W     = 32;

  // word positions inside a record
  localparam int W_MODE  = 0;
  localparam int W_BCID  = 1;
  localparam int W_HAD1  = 2;
  localparam int W_HAD2  = 3;
  localparam int W_ESUM  = 4;
  localparam int W_VVETO = 5;
  localparam int W_MUON  = 6;
  localparam int W_ELEC  = 7;
  localparam int W_MAX   = 8;
  localparam int W_RPT0  = 14;
  localparam int W_SUMPRE  = 19;
  localparam int W_SUMPOST = 20;
  localparam int W_CNT0  = 21;

  // counter slots
  localparam int C_NORM = 0;
  localparam int C_DSCL = 1;
  localparam int C_FRCD = 2;
  localparam int C_SYNC = 3;
  localparam int C_DATA = 4;
  localparam int C_WARN = 5;

  typedef struct packed {
    logic [BCID_W-1:0] bcid;
    logic [VAL_W-1:0]  had1;
    logic [VAL_W-1:0]  had2;
    logic [VAL_W-1:0]  esum;
    logic [VAL_W-1:0]  vveto;
    logic [VAL_W-1:0]  muon;
    logic [VAL_W-1:0]  elec;
    logic [RPT_W-1:0]  report;
    logic [MODE_W-1:0] mode;
    logic              accept;
    logic              dscl;
    logic              forced;
    logic              err_sync;
    logic              err_data;
  } xing_t;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [BCID_W-1:0] bcid;
    logic [VAL_W-1:0]  had1;
    logic [VAL_W-1:0]  had2;
    logic [VAL_W-1:0]  vveto;
    logic [VAL_W-1:0]  muon;
    logic [VAL_W-1:0]  elec;
    logic [HIST_DEPTH-1:0][RPT_W-1:0] report;  // [0] newest (N+2)
    logic [HIST_DEPTH-1:0][VAL_W-1:0] esum;    // [0] newest (N+2)
    logic [NUM_CNT-1:0][CNT_W-1:0]    cnt;
  } event_t;
endpackage

// File: rtl/erb_history.sv
module erb_history
  import erb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  xing_t xin,
  output xing_t [HIST_DEPTH-1:0] hist
);
  xing_t [HIST_DEPTH-1:0] hist_q;
  xing_t [HIST_DEPTH-1:0] hist_d;

  always_comb begin
    hist_d[0] = xin;
    for (int k = 1; k < HIST_DEPTH; k++) hist_d[k] = hist_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/erb_counters.sv
module erb_counters
  import erb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_CNT-1:0] inc,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cnt_nxt
);
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

  always_comb begin
    for (int k = 0; k < NUM_CNT; k++) cnt_nxt[k] = cnt_q[k] + CNT_W'(inc[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else begin
      for (int k = 0; k < NUM_CNT; k++)
        if (inc[k]) cnt_q[k] <= cnt_nxt[k];
    end
  end
endmodule

// File: rtl/erb_event_fifo.sv
module erb_event_fifo
  import erb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int WARN_LEVEL = 12,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  event_t ev_in,
  input  logic pop,
  output event_t head,
  output logic [OCC_W-1:0] occ,
  output logic full,
  output logic empty,
  output logic warn
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] OCC_WARN = OCC_W'(WARN_LEVEL);

  event_t mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             warn_q, warn_d;
  logic             do_push, do_pop;

  assign full  = (occ_q == OCC_FULL);
  assign empty = (occ_q == '0);

  always_comb begin
    do_push = push && !full;
    do_pop  = pop && !empty;
    wr_d    = wr_q;
    rd_d    = rd_q;
    occ_d   = occ_q;
    if (do_push) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
    warn_d = (occ_d >= OCC_WARN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      occ_q  <= '0;
      warn_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      occ_q  <= occ_d;
      warn_q <= warn_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= ev_in;
  end

  assign head = mem[rd_q];
  assign occ  = occ_q;
  assign warn = warn_q;
endmodule

// File: rtl/erb_word_sel.sv
module erb_word_sel
  import erb_pkg::*;
(
  input  event_t ev,
  input  logic [IDX_W-1:0] idx,
  output logic [WORD_W-1:0] word
);
  localparam int OLD2 = HIST_DEPTH - 1;
  localparam int OLD1 = HIST_DEPTH - 2;

  logic [VAL_W-1:0] max_a, max_b, max_all;
  int unsigned      pos;

  always_comb begin
    max_a   = (ev.had1 > ev.had2) ? ev.had1 : ev.had2;
    max_b   = (ev.muon > ev.elec) ? ev.muon : ev.elec;
    max_all = (max_a > max_b) ? max_a : max_b;
  end

  always_comb begin
    pos  = int'(idx);
    word = '0;
    case (pos)
      W_MODE:    word = WORD_W'(ev.mode);
      W_BCID:    word = WORD_W'(ev.bcid);
      W_HAD1:    word = WORD_W'(ev.had1);
      W_HAD2:    word = WORD_W'(ev.had2);
      W_ESUM:    word = WORD_W'(ev.esum[CENTER]);
      W_VVETO:   word = WORD_W'(ev.vveto);
      W_MUON:    word = WORD_W'(ev.muon);
      W_ELEC:    word = WORD_W'(ev.elec);
      W_MAX:     word = WORD_W'(max_all);
      W_SUMPRE:  word = {SUM_HALF'(ev.esum[OLD2]), SUM_HALF'(ev.esum[OLD1])};
      W_SUMPOST: word = {SUM_HALF'(ev.esum[1]), SUM_HALF'(ev.esum[0])};
      default:   word = '0;
    endcase
    for (int k = 0; k < HIST_DEPTH; k++)
      if (pos == W_RPT0 + k) word = WORD_W'(ev.report[HIST_DEPTH-1-k]);
    for (int k = 0; k < NUM_CNT; k++)
      if (pos == W_CNT0 + k) word = ev.cnt[k];
  end
endmodule

// File: rtl/erb_record_builder.sv
module erb_record_builder
  import erb_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int WARN_LEVEL = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] x_bcid,
  input  logic [9:0]  x_had1,
  input  logic [9:0]  x_had2,
  input  logic [9:0]  x_esum,
  input  logic [9:0]  x_vveto,
  input  logic [9:0]  x_muon,
  input  logic [9:0]  x_elec,
  input  logic [15:0] x_report,
  input  logic [2:0]  x_mode,
  input  logic        x_accept,
  input  logic        x_dscl,
  input  logic        x_forced,
  input  logic        x_err_sync,
  input  logic        x_err_data,
  output logic        rec_valid,
  output logic        rec_sop,
  output logic [31:0] rec_word,
  output logic        fifo_warn
);
  localparam int OCC_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [OCC_W-1:0] OCC_WARN = OCC_W'(WARN_LEVEL);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(REC_WORDS - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  xing_t xin;
  xing_t [HIST_DEPTH-1:0] hist;
  xing_t center;

  always_comb begin
    xin.bcid     = x_bcid;
    xin.had1     = x_had1;
    xin.had2     = x_had2;
    xin.esum     = x_esum;
    xin.vveto    = x_vveto;
    xin.muon     = x_muon;
    xin.elec     = x_elec;
    xin.report   = x_report;
    xin.mode     = x_mode;
    xin.accept   = x_accept;
    xin.dscl     = x_dscl;
    xin.forced   = x_forced;
    xin.err_sync = x_err_sync;
    xin.err_data = x_err_data;
  end

  erb_history u_hist (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .xin  (xin),
    .hist (hist)
  );

  assign center = hist[CENTER];

  // statistics
  logic [NUM_CNT-1:0]            cnt_inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_nxt;
  logic [OCC_W-1:0]              occ;
  logic                          q_full, q_empty, q_warn;

  always_comb begin
    cnt_inc         = '0;
    cnt_inc[C_NORM] = center.accept & ~center.dscl;
    cnt_inc[C_DSCL] = center.accept & center.dscl;
    cnt_inc[C_FRCD] = center.accept & center.forced;
    cnt_inc[C_SYNC] = center.err_sync;
    cnt_inc[C_DATA] = center.err_data;
    cnt_inc[C_WARN] = center.accept & (occ >= OCC_WARN);
  end

  erb_counters u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .inc    (cnt_inc),
    .cnt_nxt(cnt_nxt)
  );

  // event capture
  event_t ev_new, ev_head;
  logic   push_req, pop_req;

  always_comb begin
    ev_new.mode  = center.mode;
    ev_new.bcid  = center.bcid;
    ev_new.had1  = center.had1;
    ev_new.had2  = center.had2;
    ev_new.vveto = center.vveto;
    ev_new.muon  = center.muon;
    ev_new.elec  = center.elec;
    for (int k = 0; k < HIST_DEPTH; k++) begin
      ev_new.report[k] = hist[k].report;
      ev_new.esum[k]   = hist[k].esum;
    end
    ev_new.cnt = cnt_nxt;
    push_req   = center.accept && !q_full;
  end

  erb_event_fifo #(
    .DEPTH     (FIFO_DEPTH),
    .WARN_LEVEL(WARN_LEVEL)
  ) u_fifo (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .push (push_req),
    .ev_in(ev_new),
    .pop  (pop_req),
    .head (ev_head),
    .occ  (occ),
    .full (q_full),
    .empty(q_empty),
    .warn (q_warn)
  );

  // readout
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] sel_word;
  logic              vld_q, vld_d, sop_q, sop_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              streaming;

  erb_word_sel u_sel (
    .ev  (ev_head),
    .idx (idx_q),
    .word(sel_word)
  );

  always_comb begin
    streaming = !q_empty;
    pop_req   = streaming && (idx_q == IDX_LAST);
    idx_d     = idx_q;
    if (streaming) idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    vld_d  = streaming;
    sop_d  = streaming && (idx_q == '0);
    word_d = streaming ? sel_word : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q  <= '0;
      vld_q  <= 1'b0;
      sop_q  <= 1'b0;
      word_q <= '0;
    end else begin
      idx_q  <= idx_d;
      vld_q  <= vld_d;
      sop_q  <= sop_d;
      word_q <= word_d;
    end
  end

  assign rec_valid = vld_q;
  assign rec_sop   = sop_q;
  assign rec_word  = word_q;
  assign fifo_warn = q_warn;
endmodule

// File: rtl/erb_checker.sv
module erb_checker #(
  parameter int DEPTH = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rec_valid,
  input logic             rec_sop,
  input logic [31:0]      rec_word,
  input logic             fifo_warn,
  input logic [OCC_W-1:0] occ,
  input logic             q_full
);
  logic [5:0] pos_q;
  logic [5:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else if (rec_valid) pos_q <= rec_sop ? 6'd1 : pos_q + 6'd1;
  end
  assign cur = rec_sop ? 6'd0 : pos_q;

  AST_SOP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rec_sop |-> rec_valid); // R2
  AST_SOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rec_sop |=> (rec_valid && !rec_sop)); // R2
  AST_MID_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && cur >= 6'd1 && cur <= 6'd30) |=> (rec_valid && !rec_sop)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> (rec_word == 32'd0 && !rec_sop)); // R2
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && ((cur >= 6'd9 && cur <= 6'd13) || cur >= 6'd27)) |-> rec_word == 32'd0); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH)); // R9
  AST_WARN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> fifo_warn); // R10
endmodule

bind erb_record_builder erb_checker #(.DEPTH(FIFO_DEPTH)) u_erb_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .rec_valid(rec_valid),
  .rec_sop  (rec_sop),
  .rec_word (rec_word),
  .fifo_warn(fifo_warn),
  .occ      (occ),
  .q_full   (q_full)
);

// File: tb/test_erb_record_builder.sv
module test_erb_record_builder;
  localparam int NX = 4096;
  localparam int MAXREC = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [11:0] x_bcid;
  logic [9:0]  x_had1, x_had2, x_esum, x_vveto, x_muon, x_elec;
  logic [15:0] x_report;
  logic [2:0]  x_mode;
  logic        x_accept, x_dscl, x_forced, x_err_sync, x_err_data;
  logic        rec_valid, rec_sop, fifo_warn;
  logic [31:0] rec_word;

  erb_record_builder i_erb_record_builder (.*);

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int a_bc[NX], a_h1[NX], a_h2[NX], a_es[NX], a_vv[NX], a_mu[NX], a_el[NX], a_rp[NX], a_md[NX];
  int a_cyc[NX];
  int a_cnt[NX][6];
  int ex_x[MAXREC];
  int nexp = 0, nxing = 0;
  int c_cnt[6];
  logic [31:0] rxw[MAXREC*32];
  int rxn = 0;
  int sopcyc[MAXREC];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // one crossing per clock; mu_corner forces the muon to be the maximum
  task automatic drive(input bit acc, input bit dsc, input bit frc, input bit keep,
                       input bit winc, input bit mu_corner);
    int i;
    i = nxing;
    @(negedge clk);
    a_bc[i] = int'($urandom % 4096);
    a_h1[i] = int'($urandom % 1024);
    a_h2[i] = int'($urandom % 1024);
    a_es[i] = int'($urandom % 1024);
    a_vv[i] = int'($urandom % 1024);
    a_mu[i] = mu_corner ? 1023 : int'($urandom % 1024);
    a_el[i] = mu_corner ? 3 : int'($urandom % 1024);
    if (mu_corner) begin a_h1[i] = 1; a_h2[i] = 2; end
    a_rp[i] = int'($urandom % 65536);
    a_md[i] = int'($urandom % 8);
    x_bcid = 12'(a_bc[i]); x_had1 = 10'(a_h1[i]); x_had2 = 10'(a_h2[i]);
    x_esum = 10'(a_es[i]); x_vveto = 10'(a_vv[i]); x_muon = 10'(a_mu[i]);
    x_elec = 10'(a_el[i]); x_report = 16'(a_rp[i]); x_mode = 3'(a_md[i]);
    x_accept = acc; x_dscl = dsc; x_forced = frc;
    x_err_sync = ($urandom % 16 == 0);
    x_err_data = ($urandom % 16 == 0);
    a_cyc[i] = cyc;
    if (x_err_sync) c_cnt[3]++;
    if (x_err_data) c_cnt[4]++;
    if (acc) begin
      if (!dsc) c_cnt[0]++; else c_cnt[1]++;
      if (frc) c_cnt[2]++;
      if (winc) c_cnt[5]++;
    end
    for (int k = 0; k < 6; k++) a_cnt[i][k] = c_cnt[k];
    if (acc && keep && nexp < MAXREC) begin ex_x[nexp] = i; nexp++; end
    nxing++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'($urandom), 1'($urandom), 1'b0, 1'b0, 1'b0);
  endtask

  function automatic logic [31:0] expw(input int x, input int w);
    int m;
    m = a_h1[x];
    if (a_h2[x] > m) m = a_h2[x];
    if (a_mu[x] > m) m = a_mu[x];
    if (a_el[x] > m) m = a_el[x];
    case (w)
      0: return 32'(a_md[x]);
      1: return 32'(a_bc[x]);
      2: return 32'(a_h1[x]);
      3: return 32'(a_h2[x]);
      4: return 32'(a_es[x]);
      5: return 32'(a_vv[x]);
      6: return 32'(a_mu[x]);
      7: return 32'(a_el[x]);
      8: return 32'(m);
      14, 15, 16, 17, 18: return 32'(a_rp[x - 16 + w]);
      19: return {16'(a_es[x-2]), 16'(a_es[x-1])};
      20: return {16'(a_es[x+1]), 16'(a_es[x+2])};
      21, 22, 23, 24, 25, 26: return 32'(a_cnt[x][w-21]);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input int w);
    if (w <= 8) return "R3";
    if (w >= 14 && w <= 18) return "R4";
    if (w == 19 || w == 20) return "R5";
    if (w >= 21 && w <= 23) return "R7";
    if (w == 24 || w == 25) return "R8";
    if (w == 26) return "R10";
    return "R6";
  endfunction

  // monitor: framing R2, capture words
  always @(negedge clk) begin
    if (rec_valid) begin
      chk(rec_sop == (rxn % 32 == 0), "R2 sop position", longint'(rec_sop), longint'(rxn % 32 == 0));
      if (rec_sop && rxn / 32 < MAXREC) sopcyc[rxn/32] = cyc;
      if (rxn < MAXREC*32) rxw[rxn] = rec_word;
      rxn++;
    end
  end

  initial begin
    #200000;
    nfail++;
    $display("FAIL R2 watchdog expired, actual=%0d words expected=%0d", rxn, nexp*32);
    finish_run();
  end

  int nrand;
  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int k = 0; k < 6; k++) c_cnt[k] = 0;
    rst_n = 1'b0;
    x_bcid = '0; x_had1 = '0; x_had2 = '0; x_esum = '0; x_vveto = '0;
    x_muon = '0; x_elec = '0; x_report = '0; x_mode = '0;
    x_accept = 0; x_dscl = 0; x_forced = 0; x_err_sync = 0; x_err_data = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!rec_valid, "R1 valid", longint'(rec_valid), 0);
    chk(!rec_sop, "R1 sop", longint'(rec_sop), 0);
    chk(rec_word == 0, "R1 word", longint'(rec_word), 0);
    chk(!fifo_warn, "R1 warn", longint'(fifo_warn), 0);

    idle(5);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);   // directed: muon is the maximum
    for (int e = 0; e < 30; e++) begin
      idle(40 + int'($urandom % 20));
      drive(1'b1, 1'($urandom), 1'($urandom), 1'b1, 1'b0, 1'b0);
    end
    nrand = nexp;
    idle(60);
    chk(!fifo_warn, "R10 warn low at low occupancy", longint'(fifo_warn), 0);

    // directed burst: 20 back-to-back accepts, queue saturates
    for (int k = 0; k < 20; k++)
      drive(1'b1, 1'($urandom), 1'($urandom), k < 16, k >= 12, 1'b0);
    idle(8);
    chk(fifo_warn, "R10 warn high with full queue", longint'(fifo_warn), 1);
    idle(700);
    chk(!fifo_warn, "R10 warn low after drain", longint'(fifo_warn), 0);
    chk(!rec_valid, "R2 idle after drain", longint'(rec_valid), 0);

    for (int e = 0; e < 3; e++) begin
      idle(50);
      drive(1'b1, 1'($urandom), 1'($urandom), 1'b1, 1'b0, 1'b0);
    end
    idle(60);

    chk(rxn == nexp*32, "R9 record count", rxn, nexp*32);
    for (int r = 0; r < nexp; r++)
      for (int w = 0; w < 32; w++)
        chk(rxw[r*32+w] == expw(ex_x[r], w), req_of(w), rxw[r*32+w], expw(ex_x[r], w));
    for (int r = 0; r < nrand; r++)
      chk(sopcyc[r] - a_cyc[ex_x[r]] == 5, "R11 latency", sopcyc[r] - a_cyc[ex_x[r]], 5);
    finish_run();
  end
endmodule